// File: doc/BRIEF.md
# Dual-Clock Watchdog Timer with Keyed Feed

This block is a watchdog timer split across two clocks. Software reaches it through a small register port on the bus clock. The counting logic runs on an independent watchdog clock. A fixed divide-by-4 prescaler drives a 32-bit down-counter. The counter is loaded from a time-out constant, and the load value is never below 0xFF. The counter reloads only when a two-byte key (0xAA, then 0x55) is written to the feed register.

When the counter passes zero, the block raises one of two outputs, chosen by a mode bit. The first is a sticky interrupt line. The second is a sticky reset request, intended for the chip's reset controller. Either way, a time-out flag is also set in the mode register.

Writes to configuration reach the counting domain through toggle synchronizers with a fixed three-edge latency. The counter value reaches the bus domain through a snapshot handshake. A read therefore always returns one whole sampled value.

Both clocks may run at unrelated frequencies. A single asynchronous reset is synchronized separately into each domain. The register port has no handshake: a write takes effect on the bus-clock edge where `bus_wr` is high, and read data appears one bus-clock cycle after `bus_rd`.

Top module: `wdg_top`

## Requirements
- R1: After reset the mode register reads 0, the time-out constant reads 0xFF, the counter view reads 0xFF, and `wdg_irq` and `wdg_rst_req` are low.
- R2: While counting, the counter decrements exactly once every 4 watchdog-clock cycles, and it never increases except on a reload.
- R3: The time-out constant (offset 0x04) reads back exactly as written. A reload loads max(constant, 0xFF).
- R4: Writing 0xAA and then 0x55 (low byte of the data) to the feed register (offset 0x08) reloads the counter and starts counting, but only if mode bit 0 is set. With bit 0 clear, the sequence has no effect.
- R5: The mode register is at offset 0x00, with these bits:
  - bit 0: enable. It can be set by writing 1 and can only be cleared by reset.
  - bit 1: reset-mode select.
  - bit 2: time-out flag.
  - bit 3: read-only copy of the interrupt output.
  - Other bits read 0.
- R6: On a time-out, `wdg_rst_req` rises if reset mode is selected; otherwise `wdg_irq` rises. Both outputs stay high until reset.
- R7: The feed sequence is aborted in two cases:
  - the write after 0xAA carries a byte other than 0x55;
  - the mode or constant register is written while 0xAA is pending.

  An abort before the first valid feed has no effect. After the first valid feed, an abort forces a time-out on the third watchdog-clock edge after the aborting write.
- R8: Writes to the mode, constant and feed registers take effect on the third watchdog-clock rising edge after the bus write edge. A time-out output therefore rises on watchdog-clock edge 4·K+7 after the 0x55 write, where K = max(constant, 0xFF).
- R9: The counter view (offset 0x0C, read-only) returns a coherent snapshot. The value lies between the true count and a few ticks above it, and it decreases between spaced reads.
- R10: Every time-out sets mode bit 2. Writing the mode register with bit 2 = 0 clears it, and writing bit 2 = 1 leaves it unchanged.
- R11: After a time-out the counter halts. A later valid feed reloads it and counts again, so the next time-out sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| wclk | input | 1 | Watchdog counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| wdg_irq | output | 1 | Sticky time-out interrupt (watchdog clock domain) |
| wdg_rst_req | output | 1 | Sticky time-out reset request (watchdog clock domain) |

## Verification
The assertions check the following on every cycle:
- the counter holds between prescaler wraps and never counts upward outside a reload;
- a reload never leaves the counter below 0xFF;
- the counter stays frozen while halted;
- both time-out outputs are sticky;
- the enable bit never falls;
- the time-out flag only falls on a clearing mode write.

Only the directed scenarios can show the end-to-end timing. This covers the exact 4·K+7 edge count through the synchronizers and prescaler, and the three-edge abort path. The scenarios also cover the silent rejection of feeds before enable, and the plausibility and monotonic fall of counter snapshots read across the clock boundary.

// File: rtl/wdg_pkg.sv
`timescale 1ns/10ps
package wdg_pkg;
  localparam int CNT_W       = 32;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 5;
  localparam int PRESC_DIV   = 4;
  localparam int SYNC_STAGES = 2;
  localparam int LOAD_FLOOR  = 255;

  localparam int OFS_MODE = 'h00;
  localparam int OFS_TOUT = 'h04;
  localparam int OFS_FEED = 'h08;
  localparam int OFS_VIEW = 'h0C;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  // mode register bit positions
  localparam int MB_EN   = 0;
  localparam int MB_RSEL = 1;
  localparam int MB_TOF  = 2;
  localparam int MB_IRQ  = 3;
endpackage

// File: rtl/wdg_sync.sv
`timescale 1ns/10ps
module wdg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/wdg_bus_regs.sv
`timescale 1ns/10ps
module wdg_bus_regs #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  // synchronized levels from the counting domain
  input  logic              uf_lvl,
  input  logic              snap_lvl,
  input  logic              irq_lvl,
  input  logic [CNT_W-1:0]  snap_data,
  // toggles toward the counting domain
  output logic              ack_tgl,
  output logic              cfg_tgl,
  output logic              reload_tgl,
  output logic              kill_tgl,
  output logic              rsel_o,
  output logic [CNT_W-1:0]  tout_o
);
  localparam logic [CNT_W-1:0] TOUT_RST = CNT_W'(wdg_pkg::LOAD_FLOOR);

  logic en_r, rsel_r, tof_r, armed_r, fed_r;
  logic [CNT_W-1:0] tout_r, view_r;
  logic uf_q, snap_q, uf_p, snap_p;
  logic wr_mode, wr_tout, wr_feed;
  logic key1_hit, key2_hit, feed_ok, feed_abort;

  assign wr_mode = wr && (addr == ADDR_W'(wdg_pkg::OFS_MODE));
  assign wr_tout = wr && (addr == ADDR_W'(wdg_pkg::OFS_TOUT));
  assign wr_feed = wr && (addr == ADDR_W'(wdg_pkg::OFS_FEED));

  assign key1_hit   = wdata[7:0] == wdg_pkg::KEY_FIRST;
  assign key2_hit   = wdata[7:0] == wdg_pkg::KEY_SECOND;
  assign feed_ok    = armed_r && wr_feed && key2_hit;
  assign feed_abort = armed_r && ((wr_feed && !key2_hit) || wr_mode || wr_tout);

  assign uf_p   = uf_lvl ^ uf_q;
  assign snap_p = snap_lvl ^ snap_q;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r    <= 1'b0;
      rsel_r  <= 1'b0;
      tof_r   <= 1'b0;
      tout_r  <= TOUT_RST;
      cfg_tgl <= 1'b0;
    end else begin
      if (wr_mode) begin
        en_r   <= en_r | wdata[wdg_pkg::MB_EN];
        rsel_r <= wdata[wdg_pkg::MB_RSEL];
      end
      if (wr_tout) tout_r <= CNT_W'(wdata);
      if (wr_mode || wr_tout) cfg_tgl <= ~cfg_tgl;
      if (uf_p) tof_r <= 1'b1;
      else if (wr_mode && !wdata[wdg_pkg::MB_TOF]) tof_r <= 1'b0;
    end
  end

  // keyed feed sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_r    <= 1'b0;
      fed_r      <= 1'b0;
      reload_tgl <= 1'b0;
      kill_tgl   <= 1'b0;
    end else begin
      if (!armed_r && wr_feed && key1_hit) armed_r <= 1'b1;
      else if (feed_ok || feed_abort)      armed_r <= 1'b0;
      if (feed_ok && en_r) begin
        reload_tgl <= ~reload_tgl;
        fed_r      <= 1'b1;
      end
      if (feed_abort && en_r && fed_r) kill_tgl <= ~kill_tgl;
    end
  end

  // snapshot receive and acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q    <= 1'b0;
      snap_q  <= 1'b0;
      view_r  <= TOUT_RST;
      ack_tgl <= 1'b0;
    end else begin
      uf_q   <= uf_lvl;
      snap_q <= snap_lvl;
      if (snap_p) begin
        view_r  <= snap_data;
        ack_tgl <= ~ack_tgl;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        ADDR_W'(wdg_pkg::OFS_MODE): rdata <= DATA_W'({irq_lvl, tof_r, rsel_r, en_r});
        ADDR_W'(wdg_pkg::OFS_TOUT): rdata <= DATA_W'(tout_r);
        ADDR_W'(wdg_pkg::OFS_VIEW): rdata <= DATA_W'(view_r);
        default:                    rdata <= '0;
      endcase
    end
  end

  assign rsel_o = rsel_r;
  assign tout_o = tout_r;

  a_r5_enable_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(en_r));
  a_r10_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tof_r) |-> $past(wr_mode && !wdata[wdg_pkg::MB_TOF]));
endmodule

// File: rtl/wdg_count_core.sv
`timescale 1ns/10ps
module wdg_count_core #(
  parameter int CNT_W     = 32,
  parameter int PRESC_DIV = 4,
  parameter int FLOOR     = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_lvl,
  input  logic             reload_lvl,
  input  logic             kill_lvl,
  input  logic             ack_lvl,
  input  logic             cfg_rsel,
  input  logic [CNT_W-1:0] cfg_tout,
  output logic             irq,
  output logic             rst_req,
  output logic             uf_tgl,
  output logic             snap_tgl,
  output logic [CNT_W-1:0] snap_data
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0]    PMAX    = PW'(PRESC_DIV - 1);
  localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(FLOOR);

  logic [3:0] lvl_q;
  logic cfg_p, reload_p, kill_p, ack_p;
  logic rsel_s, rsel_nx, running, kick, tick, uf;
  logic [CNT_W-1:0] tout_s, tout_nx, load_v, cnt;
  logic [PW-1:0] presc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= {cfg_lvl, reload_lvl, kill_lvl, ack_lvl};
  end

  assign cfg_p    = cfg_lvl    ^ lvl_q[3];
  assign reload_p = reload_lvl ^ lvl_q[2];
  assign kill_p   = kill_lvl   ^ lvl_q[1];
  assign ack_p    = ack_lvl    ^ lvl_q[0];

  always_comb begin
    rsel_nx = cfg_p ? cfg_rsel : rsel_s;
    tout_nx = cfg_p ? cfg_tout : tout_s;
    load_v  = (tout_nx < FLOOR_V) ? FLOOR_V : tout_nx;
    tick    = running && (presc == PMAX);
    uf      = kill_p || (tick && (cnt == '0) && !reload_p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_s  <= 1'b0;
      tout_s  <= FLOOR_V;
      cnt     <= FLOOR_V;
      presc   <= '0;
      running <= 1'b0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
      uf_tgl  <= 1'b0;
    end else begin
      rsel_s <= rsel_nx;
      tout_s <= tout_nx;
      if (reload_p) begin
        cnt     <= load_v;
        presc   <= '0;
        running <= 1'b1;
      end else begin
        presc <= (presc == PMAX) ? '0 : presc + PW'(1);
        if (tick && (cnt != '0)) cnt <= cnt - CNT_W'(1);
      end
      if (uf) begin
        running <= 1'b0;
        uf_tgl  <= ~uf_tgl;
        if (rsel_nx) rst_req <= 1'b1;
        else         irq     <= 1'b1;
      end
    end
  end

  // snapshot launcher: one capture per acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_data <= FLOOR_V;
      snap_tgl  <= 1'b0;
      kick      <= 1'b1;
    end else if (ack_p || kick) begin
      snap_data <= cnt;
      snap_tgl  <= ~snap_tgl;
      kick      <= 1'b0;
    end
  end

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (presc != PMAX) && !reload_p) |=> $stable(cnt));
  a_r2_never_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_p |=> (cnt <= $past(cnt)));
  a_r3_floor_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    reload_p |=> (cnt >= FLOOR_V));
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq);
  a_r6_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  a_r11_halted_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !reload_p) |=> $stable(cnt));
endmodule

// File: rtl/wdg_top.sv
`timescale 1ns/10ps
module wdg_top #(
  parameter int CNT_W       = wdg_pkg::CNT_W,
  parameter int DATA_W      = wdg_pkg::DATA_W,
  parameter int ADDR_W      = wdg_pkg::ADDR_W,
  parameter int PRESC_DIV   = wdg_pkg::PRESC_DIV,
  parameter int SYNC_STAGES = wdg_pkg::SYNC_STAGES
) (
  input  logic              bclk,
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdg_irq,
  output logic              wdg_rst_req
);
  logic [1:0] b_rst_sr, w_rst_sr;
  logic b_rst_n, w_rst_n;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) b_rst_sr <= '0;
    else        b_rst_sr <= {b_rst_sr[0], 1'b1};
  end
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) w_rst_sr <= '0;
    else        w_rst_sr <= {w_rst_sr[0], 1'b1};
  end
  assign b_rst_n = b_rst_sr[1];
  assign w_rst_n = w_rst_sr[1];

  logic ack_tgl, cfg_tgl, reload_tgl, kill_tgl, rsel;
  logic [CNT_W-1:0] tout, snap_data;
  logic uf_tgl, snap_tgl;
  logic [3:0] to_w;
  logic [2:0] to_b;

  wdg_bus_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(bclk), .rst_n(b_rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .uf_lvl(to_b[2]), .snap_lvl(to_b[1]), .irq_lvl(to_b[0]), .snap_data(snap_data),
    .ack_tgl(ack_tgl), .cfg_tgl(cfg_tgl), .reload_tgl(reload_tgl), .kill_tgl(kill_tgl),
    .rsel_o(rsel), .tout_o(tout));

  wdg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync_w (
    .clk(wclk), .rst_n(w_rst_n),
    .d({cfg_tgl, reload_tgl, kill_tgl, ack_tgl}), .q(to_w));

  wdg_count_core #(.CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV), .FLOOR(wdg_pkg::LOAD_FLOOR)) u_core (
    .clk(wclk), .rst_n(w_rst_n),
    .cfg_lvl(to_w[3]), .reload_lvl(to_w[2]), .kill_lvl(to_w[1]), .ack_lvl(to_w[0]),
    .cfg_rsel(rsel), .cfg_tout(tout),
    .irq(wdg_irq), .rst_req(wdg_rst_req), .uf_tgl(uf_tgl),
    .snap_tgl(snap_tgl), .snap_data(snap_data));

  wdg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_b (
    .clk(bclk), .rst_n(b_rst_n),
    .d({uf_tgl, snap_tgl, wdg_irq}), .q(to_b));
endmodule

// File: tb/sim_wdg_top.sv
`timescale 1ns/10ps
module sim_wdg_top;
  localparam real BCLK_PERIOD = 10.0;
  localparam real WCLK_PERIOD = 7.0;
  localparam int  MAX_CYC     = 200000;

  logic bclk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wdg_irq, wdg_rst_req;

  int n_run = 0, n_fail = 0;
  int unsigned wcnt = 0;
  bit done = 0;

  wdg_top u0 (.bclk(bclk), .wclk(wclk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdg_irq(wdg_irq), .wdg_rst_req(wdg_rst_req));

  initial forever #(BCLK_PERIOD/2) bclk = ~bclk;
  initial forever #(WCLK_PERIOD/2) wclk = ~wclk;
  always @(posedge wclk) wcnt <= wcnt + 1;

  localparam logic [4:0] A_MODE = 5'h00, A_TOUT = 5'h04, A_FEED = 5'h08, A_VIEW = 5'h0C;

  task automatic chk(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_true(string req, bit ok, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_wr = 0; bus_rd = 0; rst_n = 0;
    repeat (4) @(posedge bclk);
    @(negedge bclk) rst_n = 1;
    repeat (8) @(posedge bclk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge bclk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge bclk);
    #0.1 bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge bclk);
    bus_addr = a; bus_rd = 1;
    @(posedge bclk);
    #0.1 bus_rd = 0;
    @(negedge bclk);
    d = bus_rdata;
  endtask

  // counts watchdog-clock edges from the last write until the output rises
  task automatic edges_until(bit use_rst, int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge wclk);
      n++;
      #0.1;
      if (use_rst ? wdg_rst_req : wdg_irq) break;
    end
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(A_MODE, v); chk("R1 mode", v, 0);
    rd(A_TOUT, v); chk("R1 constant", v, 'hFF);
    rd(A_VIEW, v); chk("R1 view", v, 'hFF);
    chk("R1 irq", wdg_irq, 0);
    chk("R1 rst_req", wdg_rst_req, 0);
  endtask

  task automatic t_clamp();
    logic [31:0] v; int n;
    do_reset();
    wr(A_TOUT, 'h10);
    rd(A_TOUT, v); chk("R3 raw constant readback", v, 'h10);
    wr(A_MODE, 'h1);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    edges_until(0, 3000, n);
    chk("R3 R8 clamped time-out edge count", n, 4*255+7);
    chk("R6 no reset request in irq mode", wdg_rst_req, 0);
    repeat (10) @(posedge bclk);
    rd(A_MODE, v); chk("R5 R10 mode after time-out", v, 'hD);
  endtask

  task automatic t_exact();
    int n;
    do_reset();
    wr(A_TOUT, 'h100); wr(A_MODE, 'h1);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    edges_until(0, 3000, n);
    chk("R2 R8 time-out edge count K=0x100", n, 4*256+7);
  endtask

  task automatic t_reset_mode();
    logic [31:0] v; int n;
    do_reset();
    wr(A_TOUT, 'h100); wr(A_MODE, 'h3);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    edges_until(1, 3000, n);
    chk("R6 R8 reset request edge count", n, 4*256+7);
    chk("R6 irq stays low in reset mode", wdg_irq, 0);
    repeat (10) @(posedge bclk);
    rd(A_MODE, v); chk("R5 R10 mode in reset mode", v, 'h7);
    repeat (200) @(posedge wclk);
    chk("R6 reset request sticky", wdg_rst_req, 1);
  endtask

  task automatic t_idle_abort();
    logic [31:0] v; int n;
    do_reset();
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);   // enable bit clear: ignored
    repeat (1500) @(posedge wclk);
    rd(A_VIEW, v); chk("R4 feed ignored without enable", v, 'hFF);
    wr(A_MODE, 'h1); wr(A_TOUT, 'h100);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h12);   // bad second byte before start
    wr(A_FEED, 'hAA); wr(A_MODE, 'h1); wr(A_FEED, 'h55);  // interleaved write
    repeat (1500) @(posedge wclk);
    #0.1;
    chk("R7 abort before start has no effect irq", wdg_irq, 0);
    rd(A_VIEW, v); chk("R7 abort before start leaves counter idle", v, 'hFF);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    edges_until(0, 3000, n);
    chk("R4 valid feed starts counting", n, 4*256+7);
  endtask

  task automatic t_kill();
    logic [31:0] v; int n;
    do_reset();
    wr(A_TOUT, 'h10000); wr(A_MODE, 'h1);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    repeat (20) @(posedge bclk);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h33);
    edges_until(0, 100, n);
    chk("R7 R8 bad byte forces time-out on third edge", n, 3);
    repeat (10) @(posedge bclk);
    rd(A_MODE, v); chk("R10 flag set by forced time-out", v, 'hD);
    wr(A_MODE, 'h4);
    rd(A_MODE, v); chk("R5 R10 write 1 to flag and 0 to enable keeps both", v, 'hD);
    wr(A_MODE, 'h0);
    rd(A_MODE, v); chk("R10 write 0 clears flag", v, 'h9);
    wr(A_TOUT, 'h10);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    repeat (1100) @(posedge wclk);
    repeat (10) @(posedge bclk);
    rd(A_MODE, v); chk("R11 feed after time-out restarts and times out again", v, 'hD);
    // interleaved register write aborts after start
    do_reset();
    wr(A_TOUT, 'h10000); wr(A_MODE, 'h1);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    repeat (20) @(posedge bclk);
    wr(A_FEED, 'hAA); wr(A_TOUT, 'h20000);
    edges_until(0, 100, n);
    chk("R7 interleaved write forces time-out on third edge", n, 3);
  endtask

  task automatic t_readback();
    logic [31:0] v; longint prev; int unsigned w0, e; longint k;
    k = 'h2000;
    do_reset();
    wr(A_TOUT, 32'(k)); wr(A_MODE, 'h1);
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    w0 = wcnt;
    prev = k + 1;
    for (int i = 0; i < 3; i++) begin
      repeat (40) @(posedge bclk);
      rd(A_VIEW, v);
      e = wcnt - w0;
      chk_true("R9 view not above loaded value", v <= k, v, k);
      chk_true("R9 view not below true count", longint'(v) >= k - e/4 - 1, v, k - e/4);
      chk_true("R9 view not stale", longint'(v) <= k - (e - 48)/4 + 1, v, k - (e - 48)/4);
      chk_true("R9 view decreases between reads", longint'(v) < prev, v, prev);
      prev = v;
    end
    wr(A_FEED, 'hAA); wr(A_FEED, 'h55);
    repeat (30) @(posedge bclk);
    rd(A_VIEW, v);
    chk_true("R4 feed reloads counter", (longint'(v) >= k - 20) && (v <= k), v, k);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge bclk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_clamp();
    t_exact();
    t_reset_mode();
    t_idle_abort();
    t_kill();
    t_readback();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule